// File: doc/BRIEF.md
# Speculative Task Memory Disambiguation Buffer

This block sits between a ring of task execution units and the data cache. Every task in flight is named by its ring slot, and its age is its distance from the current head slot, taken modulo the ring size. Loads and stores from tasks other than the head are tracked by address in a small set of entries. Each entry records one address, a load mark and a store mark for every ring slot, and the store data for every slot. Speculative stores stay in the buffer and reach the cache only when their task retires at the head. A load returns the value of the youngest buffered store that is not younger than the loader. When no such store exists, the load returns the cached value.

When a store finds that a younger task has already read the same address, and no task in between has written it, the block names the oldest such reader so that it and the tasks after it can be squashed. The head task never allocates an entry. Its loads read the cache, its stores write the cache in the same cycle, and it is never held back for lack of space. When a younger task needs a fresh entry and none is free, a mode input selects one of two behaviours: hold the request, or drop it and ask for that task to be squashed.

A small state machine sequences retirement. In state `ARB_RUN` the block serves requests and squashes. A retire pulse, when no squash is present in the same cycle, moves it to `ARB_COMMIT`. In `ARB_COMMIT` it visits one entry per cycle, writes the head's buffered store to the cache and clears the head's marks. It stays in `ARB_COMMIT` until it has visited the last entry, and then returns to `ARB_RUN`.

Top module: `arb_top`

## Requirements
- R1: After reset, rd_valid_o, viol_valid_o, ovf_squash_o, retire_done_o and cache_wr_en_o are low, and req_ready_o is high when no squash or retire is presented.
- R2: A load from a non-head task returns its data one cycle after acceptance, with rd_valid_o high. The data comes from the youngest buffered store at that address whose task age is less than or equal to the loader's age, and otherwise from the cache.
- R3: A store from a non-head task is held in the buffer and does not change the cache until that task retires.
- R4: A store from a task of age a to an address flags a task one cycle after acceptance, with viol_valid_o high and viol_task_o set. The flagged task is the first task, scanning ages a+1 upward, that has a load mark at that address. The scan stops without a flag at the first task in that range that has a store mark and no load mark.
- R5: Requests from the head task are never held. A head load returns the cache value, a head store writes the cache at the accepting clock edge, and neither uses an entry.
- R6: A retire pulse holds req_ready_o low for 2^ENT_W cycles. In that time the head's buffered stores are written to the cache, retire_done_o pulses exactly once, and the head's marks are cleared. Entries with no marks left become free.
- R7: A squash of task k clears, in one cycle, the marks of every task whose age is at least the age of k. After the squash, later loads no longer see those tasks' stores, and emptied entries are free.
- R8: With ovf_mode_i low (hold), a non-head request to a new address while every entry is in use sees req_ready_o low and produces no response.
- R9: With ovf_mode_i high (squash), such a request is accepted without effect. One cycle later ovf_squash_o pulses and ovf_task_o gives the requesting task.
- R10: Priority is squash, then retire, then request. req_ready_o is low while squash_i or retire_i is high and throughout the commit walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_i | input | TASK_W | Ring slot of the oldest (head) task |
| req_valid_i | input | 1 | Memory request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_task_i | input | TASK_W | Ring slot of the requesting task |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Store data |
| req_ready_o | output | 1 | Request accepted this cycle |
| rd_valid_o | output | 1 | Load data valid (one cycle after acceptance) |
| rd_data_o | output | DATA_W | Load data |
| ovf_mode_i | input | 1 | Full-buffer policy: 0 hold, 1 squash |
| ovf_squash_o | output | 1 | Request dropped for lack of space |
| ovf_task_o | output | TASK_W | Task to squash after an overflow |
| viol_valid_o | output | 1 | Memory ordering violation detected |
| viol_task_o | output | TASK_W | Oldest task that read too early |
| retire_i | input | 1 | Commit and retire the head task |
| retire_done_o | output | 1 | Last cycle of the commit walk |
| squash_i | input | 1 | Squash request |
| squash_task_i | input | TASK_W | First task (by age) to squash |
| cache_rd_addr_o | output | ADDR_W | Cache read address |
| cache_rd_data_i | input | DATA_W | Cache read data (combinational) |
| cache_wr_en_o | output | 1 | Cache write enable |
| cache_wr_addr_o | output | ADDR_W | Cache write address |
| cache_wr_data_o | output | DATA_W | Cache write data |

## Verification
A wrong mark in an entry stays hidden until a later request touches that address. A lost or stale store mark shows up on rd_data_o one cycle after a load from a younger task. A lost load mark shows up as a missing pulse on viol_valid_o one cycle after a store from an older task. Marks left behind by a retire or squash show up in two ways: the cache contents after the commit walk, or a request that the block holds or drops as an overflow when free space should exist. The sweep therefore checks every store task against every load task for every head position, and each load or store result is checked in the very next cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        ARB_RUN    = 1'b0,
        ARB_COMMIT = 1'b1
    } arb_state_e;

    typedef enum logic {
        OVF_HOLD   = 1'b0,
        OVF_SQUASH = 1'b1
    } arb_ovf_e;
endpackage

// File: rtl/arb_lookup.sv
module arb_lookup #(
    parameter int ENT_W  = 2,
    parameter int ADDR_W = 8,
    localparam int NE    = 1 << ENT_W
) (
    input  logic [NE-1:0]             ent_valid_i,
    input  logic [NE-1:0][ADDR_W-1:0] ent_addr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    output logic                      hit_o,
    output logic [ENT_W-1:0]          hit_idx_o,
    output logic                      free_o,
    output logic [ENT_W-1:0]          free_idx_o
);
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        for (int e = 0; e < NE; e++) begin
            if (ent_valid_i[e] && ent_addr_i[e] == addr_i) begin
                hit_o     = 1'b1;
                hit_idx_o = ENT_W'(e);
            end
        end
    end

    always_comb begin
        free_o     = 1'b0;
        free_idx_o = '0;
        for (int e = NE - 1; e >= 0; e--) begin
            if (!ent_valid_i[e]) begin
                free_o     = 1'b1;
                free_idx_o = ENT_W'(e);
            end
        end
    end
endmodule

// File: rtl/arb_order.sv
module arb_order #(
    parameter int TASK_W = 2,
    localparam int NT    = 1 << TASK_W
) (
    input  logic [NT-1:0]     ld_i,
    input  logic [NT-1:0]     st_i,
    input  logic [TASK_W-1:0] head_i,
    input  logic [TASK_W-1:0] task_i,
    output logic              fwd_hit_o,
    output logic [TASK_W-1:0] fwd_task_o,
    output logic              viol_hit_o,
    output logic [TASK_W-1:0] viol_task_o
);
    logic [TASK_W-1:0] age_q;
    logic [TASK_W-1:0] slot;
    logic              stop;

    assign age_q = task_i - head_i;

    always_comb begin
        fwd_hit_o   = 1'b0;
        fwd_task_o  = '0;
        viol_hit_o  = 1'b0;
        viol_task_o = '0;
        stop        = 1'b0;
        slot        = '0;
        for (int a = 0; a < NT; a++) begin
            slot = head_i + TASK_W'(a);
            if (a <= int'(age_q) && st_i[slot]) begin
                fwd_hit_o  = 1'b1;
                fwd_task_o = slot;
            end
            if (a > int'(age_q) && !stop) begin
                if (ld_i[slot]) begin
                    viol_hit_o  = 1'b1;
                    viol_task_o = slot;
                    stop        = 1'b1;
                end else if (st_i[slot]) begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import arb_pkg::*;
#(
    parameter int ENT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             squash_i,
    output logic             run_o,
    output logic             commit_o,
    output logic [ENT_W-1:0] commit_idx_o,
    output logic             done_o
);
    localparam logic [ENT_W-1:0] LAST = '1;

    arb_state_e       state_q, state_d;
    logic [ENT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_RUN;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_q == ARB_COMMIT) ? idx_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_RUN:    if (retire_i && !squash_i) state_d = ARB_COMMIT;
            ARB_COMMIT: if (idx_q == LAST)         state_d = ARB_RUN;
            default:    state_d = ARB_RUN;
        endcase
    end

    always_comb begin
        run_o        = 1'b0;
        commit_o     = 1'b0;
        done_o       = 1'b0;
        commit_idx_o = idx_q;
        unique case (state_q)
            ARB_RUN:    run_o = 1'b1;
            ARB_COMMIT: begin
                commit_o = 1'b1;
                done_o   = (idx_q == LAST);
            end
            default:    run_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/arb_top.sv
module arb_top
    import arb_pkg::*;
#(
    parameter int TASK_W = 2,
    parameter int ENT_W  = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TASK_W-1:0] head_i,
    input  logic              req_valid_i,
    input  logic              req_store_i,
    input  logic [TASK_W-1:0] req_task_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              ovf_mode_i,
    output logic              ovf_squash_o,
    output logic [TASK_W-1:0] ovf_task_o,
    output logic              viol_valid_o,
    output logic [TASK_W-1:0] viol_task_o,
    input  logic              retire_i,
    output logic              retire_done_o,
    input  logic              squash_i,
    input  logic [TASK_W-1:0] squash_task_i,
    output logic [ADDR_W-1:0] cache_rd_addr_o,
    input  logic [DATA_W-1:0] cache_rd_data_i,
    output logic              cache_wr_en_o,
    output logic [ADDR_W-1:0] cache_wr_addr_o,
    output logic [DATA_W-1:0] cache_wr_data_o
);
    localparam int NT = 1 << TASK_W;
    localparam int NE = 1 << ENT_W;

    // entry storage
    logic [NE-1:0]             ent_valid, nx_valid;
    logic [NE-1:0][ADDR_W-1:0] ent_addr;
    logic [NE-1:0][NT-1:0]     ent_ld, nx_ld;
    logic [NE-1:0][NT-1:0]     ent_st, nx_st;
    logic [DATA_W-1:0]         ent_data [NE][NT];

    logic              hit, free_avail;
    logic [ENT_W-1:0]  hit_idx, free_idx, tgt_idx;
    logic [NT-1:0]     sel_ld, sel_st, sq_mask;
    logic              fwd_hit, viol_hit;
    logic [TASK_W-1:0] fwd_task, viol_task;
    logic              run, commit, done;
    logic [ENT_W-1:0]  commit_idx;

    logic is_head, full_block, slot_open, accept, do_ovf, do_buf;
    logic [DATA_W-1:0] load_data;
    logic [TASK_W-1:0] sq_age;

    arb_lookup #(.ENT_W(ENT_W), .ADDR_W(ADDR_W)) u_lookup (
        .ent_valid_i (ent_valid),
        .ent_addr_i  (ent_addr),
        .addr_i      (req_addr_i),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx),
        .free_o      (free_avail),
        .free_idx_o  (free_idx)
    );

    assign sel_ld = hit ? ent_ld[hit_idx] : '0;
    assign sel_st = hit ? ent_st[hit_idx] : '0;

    arb_order #(.TASK_W(TASK_W)) u_order (
        .ld_i        (sel_ld),
        .st_i        (sel_st),
        .head_i      (head_i),
        .task_i      (req_task_i),
        .fwd_hit_o   (fwd_hit),
        .fwd_task_o  (fwd_task),
        .viol_hit_o  (viol_hit),
        .viol_task_o (viol_task)
    );

    arb_ctrl #(.ENT_W(ENT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire_i     (retire_i),
        .squash_i     (squash_i),
        .run_o        (run),
        .commit_o     (commit),
        .commit_idx_o (commit_idx),
        .done_o       (done)
    );

    assign retire_done_o = done;

    // request acceptance
    assign is_head     = (req_task_i == head_i);
    assign full_block  = !is_head && !hit && !free_avail;
    assign slot_open   = run && !squash_i && !retire_i;
    assign req_ready_o = slot_open && !(full_block && ovf_mode_i == OVF_HOLD);
    assign accept      = req_valid_i && req_ready_o;
    assign do_ovf      = accept && full_block;
    assign do_buf      = accept && !is_head && !full_block;
    assign tgt_idx     = hit ? hit_idx : free_idx;

    assign cache_rd_addr_o = req_addr_i;

    always_comb begin
        load_data = cache_rd_data_i;
        if (!is_head && fwd_hit) load_data = ent_data[hit_idx][fwd_task];
    end

    // cache write port: commit walk or head store
    always_comb begin
        cache_wr_en_o   = 1'b0;
        cache_wr_addr_o = req_addr_i;
        cache_wr_data_o = req_wdata_i;
        if (commit) begin
            cache_wr_en_o   = ent_valid[commit_idx] && ent_st[commit_idx][head_i];
            cache_wr_addr_o = ent_addr[commit_idx];
            cache_wr_data_o = ent_data[commit_idx][head_i];
        end else if (accept && req_store_i && is_head) begin
            cache_wr_en_o = 1'b1;
        end
    end

    // squash mask by age
    assign sq_age = squash_task_i - head_i;
    generate
        for (genvar t = 0; t < NT; t++) begin : g_sqmask
            logic [TASK_W-1:0] t_age;
            assign t_age      = TASK_W'(t) - head_i;
            assign sq_mask[t] = squash_i && (t_age >= sq_age);
        end
    endgenerate

    // next-state of marks
    always_comb begin
        nx_valid = ent_valid;
        nx_ld    = ent_ld;
        nx_st    = ent_st;
        for (int e = 0; e < NE; e++) begin
            nx_ld[e] = nx_ld[e] & ~sq_mask;
            nx_st[e] = nx_st[e] & ~sq_mask;
        end
        if (commit) begin
            nx_ld[commit_idx][head_i] = 1'b0;
            nx_st[commit_idx][head_i] = 1'b0;
        end
        if (do_buf) begin
            nx_valid[tgt_idx] = 1'b1;
            if (req_store_i) nx_st[tgt_idx][req_task_i] = 1'b1;
            else             nx_ld[tgt_idx][req_task_i] = 1'b1;
        end
        for (int e = 0; e < NE; e++) begin
            if (nx_ld[e] == '0 && nx_st[e] == '0) nx_valid[e] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_ld    <= '0;
            ent_st    <= '0;
        end else begin
            ent_valid <= nx_valid;
            ent_ld    <= nx_ld;
            ent_st    <= nx_st;
        end
    end

    generate
        for (genvar e = 0; e < NE; e++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_addr[e] <= '0;
                end else if (do_buf && !hit && tgt_idx == ENT_W'(e)) begin
                    ent_addr[e] <= req_addr_i;
                end
            end
            always_ff @(posedge clk) begin
                if (do_buf && req_store_i && tgt_idx == ENT_W'(e))
                    ent_data[e][req_task_i] <= req_wdata_i;
            end
        end
    endgenerate

    // registered responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o   <= 1'b0;
            rd_data_o    <= '0;
            viol_valid_o <= 1'b0;
            viol_task_o  <= '0;
            ovf_squash_o <= 1'b0;
            ovf_task_o   <= '0;
        end else begin
            rd_valid_o   <= accept && !req_store_i && !full_block;
            rd_data_o    <= load_data;
            viol_valid_o <= accept && req_store_i && !full_block && hit && viol_hit;
            viol_task_o  <= viol_task;
            ovf_squash_o <= do_ovf;
            ovf_task_o   <= req_task_i;
        end
    end
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int TASK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [TASK_W-1:0] head_i,
    input logic              req_valid_i,
    input logic              req_store_i,
    input logic [TASK_W-1:0] req_task_i,
    input logic              req_ready_o,
    input logic              rd_valid_o,
    input logic              ovf_mode_i,
    input logic              ovf_squash_o,
    input logic              viol_valid_o,
    input logic [TASK_W-1:0] viol_task_o,
    input logic              retire_i,
    input logic              retire_done_o,
    input logic              squash_i,
    input logic              cache_wr_en_o
);
    assert_head_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !squash_i && !retire_i && req_valid_i && req_task_i == head_i) |-> req_ready_o);

    assert_no_spec_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_wr_en_o && run) |-> (req_valid_i && req_store_i && req_ready_o && req_task_i == head_i));

    assert_viol_younger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid_o |-> (TASK_W'(viol_task_o - $past(head_i)) > TASK_W'($past(req_task_i) - $past(head_i))));

    assert_ovf_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_squash_o |-> $past(ovf_mode_i));

    assert_rd_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(req_valid_i && req_ready_o && !req_store_i));

    assert_commit_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || squash_i || retire_i) |-> !req_ready_o);

    assert_done_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_done_o |=> run);
endmodule

bind arb_top arb_checker #(.TASK_W(TASK_W)) u_arb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .head_i        (head_i),
    .req_valid_i   (req_valid_i),
    .req_store_i   (req_store_i),
    .req_task_i    (req_task_i),
    .req_ready_o   (req_ready_o),
    .rd_valid_o    (rd_valid_o),
    .ovf_mode_i    (ovf_mode_i),
    .ovf_squash_o  (ovf_squash_o),
    .viol_valid_o  (viol_valid_o),
    .viol_task_o   (viol_task_o),
    .retire_i      (retire_i),
    .retire_done_o (retire_done_o),
    .squash_i      (squash_i),
    .cache_wr_en_o (cache_wr_en_o)
);

// File: tb/tb_arb_top.sv
module tb_arb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 2;
    localparam int EW = 2;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NT = 1 << TW;
    localparam int NE = 1 << EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] head_i = '0;
    logic          req_valid_i = 1'b0, req_store_i = 1'b0;
    logic [TW-1:0] req_task_i = '0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_wdata_i = '0;
    logic          req_ready_o, rd_valid_o, ovf_squash_o, viol_valid_o, retire_done_o;
    logic [DW-1:0] rd_data_o;
    logic          ovf_mode_i = 1'b0;
    logic [TW-1:0] ovf_task_o, viol_task_o;
    logic          retire_i = 1'b0, squash_i = 1'b0;
    logic [TW-1:0] squash_task_i = '0;
    logic [AW-1:0] cache_rd_addr_o, cache_wr_addr_o;
    logic [DW-1:0] cache_rd_data_i, cache_wr_data_o;
    logic          cache_wr_en_o;

    logic [DW-1:0] cmem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cache_rd_data_i = cmem[cache_rd_addr_o];
    always @(posedge clk) if (cache_wr_en_o) cmem[cache_wr_addr_o] <= cache_wr_data_o;

    arb_top #(.TASK_W(TW), .ENT_W(EW), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .head_i(head_i),
        .req_valid_i(req_valid_i), .req_store_i(req_store_i), .req_task_i(req_task_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_ready_o(req_ready_o),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .ovf_mode_i(ovf_mode_i),
        .ovf_squash_o(ovf_squash_o), .ovf_task_o(ovf_task_o),
        .viol_valid_o(viol_valid_o), .viol_task_o(viol_task_o),
        .retire_i(retire_i), .retire_done_o(retire_done_o),
        .squash_i(squash_i), .squash_task_i(squash_task_i),
        .cache_rd_addr_o(cache_rd_addr_o), .cache_rd_data_i(cache_rd_data_i),
        .cache_wr_en_o(cache_wr_en_o), .cache_wr_addr_o(cache_wr_addr_o),
        .cache_wr_data_o(cache_wr_data_o)
    );

    // reference model (addresses below 64 only)
    int n_chk = 0;
    int n_fail = 0;
    int head = 0;
    bit m_ld [64][NT];
    bit m_st [64][NT];
    int m_dat [64][NT];
    int ecache [256];

    function automatic int age(int t);
        return (t - head + NT) % NT;
    endfunction

    function automatic int slot(int a);
        return (head + a) % NT;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_cache(string req);
        int errs = 0;
        for (int a = 0; a < 64; a++) if (int'(cmem[a]) != ecache[a]) errs++;
        chk(req, "cache mismatches", errs, 0);
    endtask

    task automatic do_req(bit st, int t, int a, int wd);
        bit hd = (t == head);
        int exp_rd = ecache[a];
        bit exp_v = 0;
        int exp_vt = 0;
        bit stop = 0;
        if (!st) begin
            if (!hd) for (int g = 0; g <= age(t); g++) if (m_st[a][slot(g)]) exp_rd = m_dat[a][slot(g)];
        end else begin
            for (int g = age(t) + 1; g < NT; g++) begin
                if (!stop) begin
                    if (m_ld[a][slot(g)]) begin exp_v = 1; exp_vt = slot(g); stop = 1; end
                    else if (m_st[a][slot(g)]) stop = 1;
                end
            end
        end
        req_valid_i = 1'b1; req_store_i = st; req_task_i = TW'(t);
        req_addr_i = AW'(a); req_wdata_i = DW'(wd);
        #1;
        chk(hd ? "R5" : "R2", "ready", int'(req_ready_o), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        if (!st) begin
            if (!hd) m_ld[a][t] = 1;
            chk("R2", "rd_valid", int'(rd_valid_o), 1);
            chk(hd ? "R5" : "R2", "rd_data", int'(rd_data_o), exp_rd);
            chk("R4", "no viol on load", int'(viol_valid_o), 0);
        end else begin
            if (hd) begin
                ecache[a] = wd;
                chk("R5", "head store in cache", int'(cmem[a]), wd);
            end else begin
                m_st[a][t] = 1; m_dat[a][t] = wd;
                chk("R3", "cache untouched", int'(cmem[a]), ecache[a]);
            end
            chk("R4", "viol_valid", int'(viol_valid_o), int'(exp_v));
            if (exp_v) chk("R4", "viol_task", int'(viol_task_o), exp_vt);
            chk("R2", "no rd on store", int'(rd_valid_o), 0);
        end
    endtask

    task automatic squash_t(int k);
        int ka = age(k);
        squash_i = 1'b1; squash_task_i = TW'(k); req_valid_i = 1'b1;
        req_task_i = TW'(head); req_store_i = 1'b0;
        #1;
        chk("R10", "ready low under squash", int'(req_ready_o), 0);
        @(posedge clk);
        @(negedge clk);
        squash_i = 1'b0; req_valid_i = 1'b0;
        for (int a = 0; a < 64; a++)
            for (int t = 0; t < NT; t++)
                if (age(t) >= ka) begin m_ld[a][t] = 0; m_st[a][t] = 0; end
    endtask

    task automatic retire_t();
        int seen = 0;
        retire_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        retire_i = 1'b0;
        for (int i = 0; i < NE; i++) begin
            chk("R6", "ready low in commit", int'(req_ready_o), 0);
            if (retire_done_o) seen++;
            @(posedge clk);
            @(negedge clk);
        end
        chk("R6", "done pulses", seen, 1);
        for (int a = 0; a < 64; a++) begin
            if (m_st[a][head]) ecache[a] = m_dat[a][head];
            m_ld[a][head] = 0; m_st[a][head] = 0;
        end
        head = (head + 1) % NT;
        head_i = TW'(head);
        cmp_cache("R6");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            cmem[a] = DW'(a * 3 + 100);
            ecache[a] = a * 3 + 100;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_valid", int'(rd_valid_o), 0);
        chk("R1", "viol_valid", int'(viol_valid_o), 0);
        chk("R1", "ovf_squash", int'(ovf_squash_o), 0);
        chk("R1", "retire_done", int'(retire_done_o), 0);
        chk("R1", "cache_wr_en", int'(cache_wr_en_o), 0);
        chk("R1", "ready", int'(req_ready_o), 1);

        // sweep: every head, store task, load task
        for (int h = 0; h < NT; h++) begin
            for (int s = 0; s < NT; s++) begin
                for (int l = 0; l < NT; l++) begin
                    do_req(0, l, 5, 0);
                    do_req(1, s, 5, 1000 + h * 16 + s * 4 + l);
                    do_req(0, l, 5, 0);
                    squash_t(slot(1));
                end
            end
            retire_t();
        end

        // intervening stores and oldest reader (R4)
        squash_t(slot(1));
        do_req(0, slot(3), 31, 0);
        do_req(1, slot(2), 31, 700);
        squash_t(slot(1));
        do_req(1, slot(2), 32, 710);
        do_req(0, slot(3), 32, 0);
        do_req(1, slot(1), 32, 711);
        squash_t(slot(1));
        do_req(0, slot(2), 33, 0);
        do_req(0, slot(3), 33, 0);
        do_req(1, slot(1), 33, 720);
        squash_t(slot(1));

        // squash removes forwarding (R7)
        do_req(1, slot(2), 3, 900);
        do_req(0, slot(3), 3, 0);
        squash_t(slot(2));
        do_req(0, slot(3), 3, 0);
        squash_t(slot(1));

        // commit ordering and head bypass (R6, R5)
        do_req(1, slot(1), 20, 500);
        do_req(1, slot(1), 21, 501);
        do_req(1, slot(2), 20, 502);
        retire_t();
        retire_t();
        do_req(0, slot(2), 20, 0);
        retire_t();
        do_req(1, head, 22, 503);
        squash_t(slot(1));

        // overflow, hold mode (R8)
        for (int i = 0; i < NE; i++) do_req(0, slot(1), 40 + i, 0);
        ovf_mode_i = 1'b0;
        req_valid_i = 1'b1; req_store_i = 1'b0; req_task_i = TW'(slot(2)); req_addr_i = 8'd50;
        #1;
        chk("R8", "ready held low", int'(req_ready_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", "no response", int'(rd_valid_o), 0);
        chk("R8", "still held", int'(req_ready_o), 0);
        req_valid_i = 1'b0;
        do_req(0, head, 50, 0);
        do_req(0, slot(2), 41, 0);
        // overflow, squash mode (R9)
        ovf_mode_i = 1'b1;
        req_valid_i = 1'b1; req_store_i = 1'b1; req_task_i = TW'(slot(3));
        req_addr_i = 8'd51; req_wdata_i = 16'd999;
        #1;
        chk("R9", "ready in squash mode", int'(req_ready_o), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R9", "ovf_squash", int'(ovf_squash_o), 1);
        chk("R9", "ovf_task", int'(ovf_task_o), slot(3));
        chk("R9", "no viol", int'(viol_valid_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "ovf pulse ends", int'(ovf_squash_o), 0);
        ovf_mode_i = 1'b0;
        squash_t(slot(1));
        do_req(0, slot(3), 51, 0);
        cmp_cache("R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule